// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block collects every reset request a small processor core can raise and turns them into one system reset output. The requests are a power-on pulse, the external reset pin (while running or while asleep), the watchdog, brown-out, a software reset instruction, trap lockup, and an illegal opcode or uninitialized pointer fault. The system reset stays asserted for as long as any request is active. The threshold detectors and the clock generator sit outside the block and reach it as digital inputs. The pin is only observed and never driven.

A low level on the external pin counts only after a digital noise filter has seen it for `FILT_LEN` consecutive clocks. After a power-on event the sequencer waits a fixed power-on delay of `POR_TICKS` reference ticks and then a power-up time-out chosen by configuration. After a brown-out only the time-out is rerun. All other causes skip both delays. Release always happens on a clock where the instruction-phase-one strobe is high.

The reason for the last reset is kept in eight sticky flags that software clears by writing ones. A watchdog expiry during sleep does not reset the system: it sets its flag and raises a one-clock wake pulse.

Top module: `reset_cause_sequencer`

## Requirements
- R1: The pin request becomes active only after `pin_n_i` has been sampled low on `FILT_LEN` consecutive clocks. A low pulse shorter than that causes no reset and sets no flag.
- R2: While any request is active, `sysrst_o` is 1 from the clock after it is sampled and stays 1 for as long as it lasts.
- R3: After a power-on event (`por_i`, or the release of `arst_n`), release waits `POR_TICKS` pulses of `tick_i` and then the selected time-out.
- R4: `pwrt_sel_i` sets the time-out in ticks: 00 gives 0, 01 gives 4·`MS_TICKS`, 10 gives 16·`MS_TICKS`, 11 gives 64·`MS_TICKS`.
- R5: With `boren_i`=1, `bor_i` resets the system, sets flag bit 1 and reruns only the time-out. With `boren_i`=0, `bor_i` has no effect on the reset or on the flags.
- R6: `sysrst_o` falls only on a clock edge where `q1_i` is 1. Pin, watchdog, software, trap and illegal-opcode resets apply no delay before that alignment.
- R7: `wdt_i` together with `sleep_i`=1 leaves `sysrst_o` at 0, sets flag bit 4 and makes `wake_o` 1 for exactly the next clock.
- R8: Flag bit positions in `cause_o`: 0 power-on, 1 brown-out, 2 pin while running, 3 pin while asleep, 4 watchdog, 5 software reset, 6 trap lockup, 7 illegal opcode or pointer. A cause sets its bit and the bit stays set.
- R9: After `arst_n` or a `por_i` pulse, `cause_o` is 8'h01 and `sysrst_o` is 1.
- R10: When `clr_we_i`=1, every `cause_o` bit that has a 1 in `clr_mask_i` is cleared. A cause active in the same clock wins, and its bit stays 1.
- R11: A filtered pin request sets bit 3 when `sleep_i`=1 and bit 2 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, treated as a power-on event |
| tick_i | input | 1 | One-clock pulse of the delay reference timebase |
| q1_i | input | 1 | High in the first phase of each instruction cycle |
| por_i | input | 1 | Power-on detector pulse |
| pin_n_i | input | 1 | External reset pin, active low, unfiltered |
| sleep_i | input | 1 | Core is in sleep |
| wdt_i | input | 1 | Watchdog expiry |
| bor_i | input | 1 | Brown-out detector output |
| boren_i | input | 1 | Brown-out reset enable |
| swrst_i | input | 1 | Software reset instruction |
| trap_i | input | 1 | Trap lockup |
| illop_i | input | 1 | Illegal opcode or uninitialized pointer use |
| pwrt_sel_i | input | 2 | Power-up time-out select |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 8 | Write-one-to-clear mask for the flags |
| sysrst_o | output | 1 | System reset, active high |
| cause_o | output | 8 | Sticky reset-cause flags |
| wake_o | output | 1 | Wake pulse after a watchdog expiry in sleep |

## Verification
On every cycle the assertions check the following:
- a sampled request asserts the reset on the next clock;
- a release edge always coincides with the phase-one strobe;
- a high pin level clears the filter;
- flags never drop without a clear or a power-on;
- a watchdog expiry in sleep leaves a running system running.

The exact durations need the bench's scenarios: the tick counts behind each time-out setting, and the brown-out path skipping the power-on delay. The bench's scenarios also cover filter lengths at and below the threshold, and the priority of a new cause over a clear in the same clock.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int NCAUSE = 8;

  localparam int CB_POR   = 0;
  localparam int CB_BOR   = 1;
  localparam int CB_PINR  = 2;
  localparam int CB_PINS  = 3;
  localparam int CB_WDT   = 4;
  localparam int CB_SWR   = 5;
  localparam int CB_TRAP  = 6;
  localparam int CB_ILL   = 7;

  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_PORDLY = 3'd1,
    ST_PWRT   = 3'd2,
    ST_ALIGN  = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_e;
endpackage

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_n_i,
  output logic active_o
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam logic [FW-1:0] FULL = FW'(FILT_LEN);

  logic [FW-1:0] run_q, run_d;

  always_comb begin
    if (pin_n_i)           run_d = '0;
    else if (run_q == FULL) run_d = run_q;
    else                   run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) run_q <= '0;
    else         run_q <= run_d;
  end

  assign active_o = (run_q == FULL);

  AST_FILT_SHORT: assert property (@(posedge clk) disable iff (!arst_n)
    pin_n_i |=> !active_o); // R1
  AST_FILT_KEEP: assert property (@(posedge clk) disable iff (!arst_n)
    (active_o && !pin_n_i) |=> active_o); // R1
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer
  import rstseq_pkg::*;
#(
  parameter int POR_TICKS = 10,
  parameter int MS_TICKS  = 1000
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       req_i,
  input  logic       por_i,
  input  logic       bor_i,
  input  logic       tick_i,
  input  logic       q1_i,
  input  logic [1:0] pwrt_sel_i,
  output logic       sysrst_o
);
  localparam int LMAX = (64 * MS_TICKS > POR_TICKS) ? 64 * MS_TICKS : POR_TICKS;
  localparam int CW   = $clog2(LMAX + 1);
  localparam logic [CW-1:0] POR_LAST = CW'(POR_TICKS - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          npor_q, npor_d, npwrt_q, npwrt_d;

  always_comb begin
    unique case (pwrt_sel_i)
      2'd0:    lim = '0;
      2'd1:    lim = CW'(4 * MS_TICKS);
      2'd2:    lim = CW'(16 * MS_TICKS);
      default: lim = CW'(64 * MS_TICKS);
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    npor_d  = npor_q;
    npwrt_d = npwrt_q;
    if (req_i) begin
      state_d = ST_HOLD;
      cnt_d   = '0;
      npor_d  = npor_q | por_i;
      npwrt_d = npwrt_q | por_i | bor_i;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          cnt_d = '0;
          if (npor_q)       state_d = ST_PORDLY;
          else if (npwrt_q) state_d = ST_PWRT;
          else              state_d = ST_ALIGN;
        end
        ST_PORDLY: begin
          if (tick_i) begin
            if (cnt_q == POR_LAST) begin
              cnt_d   = '0;
              npor_d  = 1'b0;
              state_d = ST_PWRT;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_PWRT: begin
          if (lim == '0) begin
            npwrt_d = 1'b0;
            state_d = ST_ALIGN;
          end else if (tick_i) begin
            if (cnt_q == lim - 1'b1) begin
              cnt_d   = '0;
              npwrt_d = 1'b0;
              state_d = ST_ALIGN;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_ALIGN: begin
          if (q1_i) state_d = ST_RUN;
        end
        ST_RUN: state_d = ST_RUN;
        default: state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      npor_q  <= 1'b1;
      npwrt_q <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      npor_q  <= npor_d;
      npwrt_q <= npwrt_d;
    end
  end

  assign sysrst_o = (state_q != ST_RUN);

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    req_i |=> sysrst_o); // R2
  AST_RELEASE_Q1: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(sysrst_o) |-> $past(q1_i)); // R6
  AST_POR_RESTART: assert property (@(posedge clk) disable iff (!arst_n)
    por_i |=> (sysrst_o && npor_q)); // R3
endmodule

// File: rtl/rstseq_cause_flags.sv
module rstseq_cause_flags
  import rstseq_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  logic [NCAUSE-1:0] set_i,
  input  logic              por_i,
  input  logic              clr_we_i,
  input  logic [NCAUSE-1:0] clr_mask_i,
  output logic [NCAUSE-1:0] cause_o
);
  localparam logic [NCAUSE-1:0] POR_ONLY = NCAUSE'(1) << CB_POR;

  logic [NCAUSE-1:0] cause_q, cause_d, keep;
  logic              upd;

  always_comb begin
    keep    = clr_we_i ? ~clr_mask_i : '1;
    upd     = por_i | clr_we_i | (|set_i);
    cause_d = por_i ? POR_ONLY : ((cause_q & keep) | set_i);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  cause_q <= POR_ONLY;
    else if (upd) cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  AST_POR_ONLY: assert property (@(posedge clk) disable iff (!arst_n)
    por_i |=> (cause_o == POR_ONLY)); // R9
  AST_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
    (!por_i && !clr_we_i) |=> ((cause_o & $past(cause_o)) == $past(cause_o))); // R10
  AST_SET_SEEN: assert property (@(posedge clk) disable iff (!arst_n)
    (!por_i && (|set_i)) |=> ((cause_o & $past(set_i)) == $past(set_i))); // R8
endmodule

// File: rtl/reset_cause_sequencer.sv
module reset_cause_sequencer
  import rstseq_pkg::*;
#(
  parameter int FILT_LEN  = 4,
  parameter int POR_TICKS = 10,
  parameter int MS_TICKS  = 1000
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       tick_i,
  input  logic       q1_i,
  input  logic       por_i,
  input  logic       pin_n_i,
  input  logic       sleep_i,
  input  logic       wdt_i,
  input  logic       bor_i,
  input  logic       boren_i,
  input  logic       swrst_i,
  input  logic       trap_i,
  input  logic       illop_i,
  input  logic [1:0] pwrt_sel_i,
  input  logic       clr_we_i,
  input  logic [7:0] clr_mask_i,
  output logic       sysrst_o,
  output logic [7:0] cause_o,
  output logic       wake_o
);
  logic              pin_act, bor_eff, wdt_run, wdt_slp, any_req;
  logic [NCAUSE-1:0] set_vec;
  logic              wake_q;

  rstseq_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk      (clk),
    .arst_n   (arst_n),
    .pin_n_i  (pin_n_i),
    .active_o (pin_act)
  );

  always_comb begin
    bor_eff = bor_i & boren_i;
    wdt_run = wdt_i & ~sleep_i;
    wdt_slp = wdt_i & sleep_i;
    any_req = por_i | pin_act | wdt_run | bor_eff | swrst_i | trap_i | illop_i;
    set_vec          = '0;
    set_vec[CB_BOR]  = bor_eff;
    set_vec[CB_PINR] = pin_act & ~sleep_i;
    set_vec[CB_PINS] = pin_act & sleep_i;
    set_vec[CB_WDT]  = wdt_i;
    set_vec[CB_SWR]  = swrst_i;
    set_vec[CB_TRAP] = trap_i;
    set_vec[CB_ILL]  = illop_i;
  end

  rstseq_timer #(.POR_TICKS(POR_TICKS), .MS_TICKS(MS_TICKS)) u_tmr (
    .clk        (clk),
    .arst_n     (arst_n),
    .req_i      (any_req),
    .por_i      (por_i),
    .bor_i      (bor_eff),
    .tick_i     (tick_i),
    .q1_i       (q1_i),
    .pwrt_sel_i (pwrt_sel_i),
    .sysrst_o   (sysrst_o)
  );

  rstseq_cause_flags u_flags (
    .clk        (clk),
    .arst_n     (arst_n),
    .set_i      (set_vec),
    .por_i      (por_i),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .cause_o    (cause_o)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) wake_q <= 1'b0;
    else         wake_q <= wdt_slp;
  end

  assign wake_o = wake_q;

  AST_SLEEP_WDT: assert property (@(posedge clk) disable iff (!arst_n)
    (wdt_slp && !any_req && !sysrst_o) |=> !sysrst_o); // R7
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_slp |=> wake_o); // R7
  AST_BOR_GATED: assert property (@(posedge clk) disable iff (!arst_n)
    (bor_i && !boren_i && !any_req && !sysrst_o) |=> !sysrst_o); // R5
endmodule

// File: tb/reset_cause_sequencer_test.sv
`timescale 1ns/1ps
module reset_cause_sequencer_test;
  localparam int FILT = 4;
  localparam int PORT = 10;
  localparam int MST  = 2;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       tick_i = 1'b0, q1_i = 1'b0;
  logic       por_i = 1'b0, pin_n_i = 1'b1, sleep_i = 1'b0, wdt_i = 1'b0;
  logic       bor_i = 1'b0, boren_i = 1'b0, swrst_i = 1'b0, trap_i = 1'b0, illop_i = 1'b0;
  logic [1:0] pwrt_sel_i = 2'd1;
  logic       clr_we_i = 1'b0;
  logic [7:0] clr_mask_i = 8'h00;
  logic       sysrst_o, wake_o;
  logic [7:0] cause_o;

  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  reset_cause_sequencer #(.FILT_LEN(FILT), .POR_TICKS(PORT), .MS_TICKS(MST)) uut (
    .clk(clk), .arst_n(arst_n), .tick_i(tick_i), .q1_i(q1_i), .por_i(por_i),
    .pin_n_i(pin_n_i), .sleep_i(sleep_i), .wdt_i(wdt_i), .bor_i(bor_i),
    .boren_i(boren_i), .swrst_i(swrst_i), .trap_i(trap_i), .illop_i(illop_i),
    .pwrt_sel_i(pwrt_sel_i), .clr_we_i(clr_we_i), .clr_mask_i(clr_mask_i),
    .sysrst_o(sysrst_o), .cause_o(cause_o), .wake_o(wake_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    nchk++;
    if (act < lo || act > hi) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  // Reference model: behavioural, evaluated on each rising edge
  int   m_run, m_st, m_cnt, m_lim;
  bit   m_npor, m_npwrt, m_wake, m_pa, m_req, m_boe;
  logic [7:0] m_cause, m_set;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_run = 0; m_st = 0; m_cnt = 0; m_npor = 1; m_npwrt = 1;
      m_cause = 8'h01; m_wake = 0;
    end else begin
      m_pa  = (m_run >= FILT);
      m_run = pin_n_i ? 0 : ((m_run >= FILT) ? FILT : m_run + 1);
      m_boe = bor_i && boren_i;
      m_req = por_i || m_pa || (wdt_i && !sleep_i) || m_boe || swrst_i || trap_i || illop_i;
      m_set = {illop_i, trap_i, swrst_i, wdt_i, m_pa && sleep_i, m_pa && !sleep_i, m_boe, 1'b0};
      if (por_i) m_cause = 8'h01;
      else begin
        if (clr_we_i) m_cause = m_cause & ~clr_mask_i;
        m_cause = m_cause | m_set;
      end
      m_wake = wdt_i && sleep_i;
      case (pwrt_sel_i)
        2'd0: m_lim = 0;
        2'd1: m_lim = 4 * MST;
        2'd2: m_lim = 16 * MST;
        default: m_lim = 64 * MST;
      endcase
      if (m_req) begin
        m_st = 0; m_cnt = 0;
        if (por_i) m_npor = 1;
        if (por_i || m_boe) m_npwrt = 1;
      end else if (m_st == 0) begin
        m_cnt = 0;
        m_st = m_npor ? 1 : (m_npwrt ? 2 : 3);
      end else if (m_st == 1) begin
        if (tick_i) begin
          m_cnt++;
          if (m_cnt == PORT) begin m_cnt = 0; m_npor = 0; m_st = 2; end
        end
      end else if (m_st == 2) begin
        if (m_lim == 0) begin m_npwrt = 0; m_st = 3; end
        else if (tick_i) begin
          m_cnt++;
          if (m_cnt == m_lim) begin m_cnt = 0; m_npwrt = 0; m_st = 3; end
        end
      end else if (m_st == 3) begin
        if (q1_i) m_st = 4;
      end
    end
  end

  always @(negedge clk) begin
    if (arst_n) begin
      chk("R2 sysrst", int'(sysrst_o), int'(m_st != 4));
      chk("R8 cause", int'(cause_o), int'(m_cause));
      chk("R7 wake", int'(wake_o), int'(m_wake));
    end
  end

  // timebase: tick and phase-one strobes every fourth clock
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      tick_i = (ph == 1);
      q1_i   = (ph == 3);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    while (sysrst_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_por();
    por_i = 1'b1; cyc(1); por_i = 1'b0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R9 reset sysrst", int'(sysrst_o), 1);
    chk("R9 reset cause", int'(cause_o), 8'h01);
    arst_n = 1'b1;
    measure(n);
    chk_rng("R3 power-on release cycles", n, 68, 84);
    cyc(2);

    // R1: short pin pulse ignored
    pin_n_i = 1'b0; cyc(FILT - 1); pin_n_i = 1'b1; cyc(3);
    chk("R1 short pulse no reset", int'(sysrst_o), 0);
    chk("R1 short pulse no flag", int'(cause_o), 8'h01);

    // R1/R11: long pin low while running
    pin_n_i = 1'b0; cyc(FILT + 2);
    chk("R1 long pulse resets", int'(sysrst_o), 1);
    chk("R11 pin run flag", int'(cause_o), 8'h05);
    pin_n_i = 1'b1;
    measure(n);
    chk_rng("R6 pin release without delay", n, 1, 10);
    cyc(2);

    // R10: clear all, then set wins over clear
    clr_we_i = 1'b1; clr_mask_i = 8'hFF; cyc(1); clr_we_i = 1'b0;
    chk("R10 clear all", int'(cause_o), 8'h00);
    swrst_i = 1'b1; clr_we_i = 1'b1; clr_mask_i = 8'h20; cyc(1);
    clr_we_i = 1'b0;
    chk("R10 set wins over clear", int'(cause_o), 8'h20);
    // R2: long request keeps reset
    cyc(50);
    chk("R2 held request keeps reset", int'(sysrst_o), 1);
    swrst_i = 1'b0;
    measure(n);
    chk_rng("R6 software release without delay", n, 1, 10);
    cyc(2);

    // R7: watchdog during sleep
    sleep_i = 1'b1; wdt_i = 1'b1; cyc(1); wdt_i = 1'b0;
    chk("R7 wake pulse", int'(wake_o), 1);
    chk("R7 no reset in sleep", int'(sysrst_o), 0);
    chk("R7 watchdog flag", int'(cause_o), 8'h30);
    cyc(1);
    chk("R7 wake one clock", int'(wake_o), 0);

    // R11: pin during sleep
    pin_n_i = 1'b0; cyc(FILT + 1); pin_n_i = 1'b1;
    chk("R11 pin sleep flag", int'(cause_o), 8'h38);
    sleep_i = 1'b0;
    measure(n);
    cyc(2);

    // R8: watchdog while running
    clr_we_i = 1'b1; clr_mask_i = 8'hFF; cyc(1); clr_we_i = 1'b0;
    wdt_i = 1'b1; cyc(1); wdt_i = 1'b0;
    chk("R8 watchdog run resets", int'(sysrst_o), 1);
    chk("R8 watchdog bit 4", int'(cause_o), 8'h10);
    measure(n);
    cyc(2);

    // R5: brown-out disabled, then enabled
    boren_i = 1'b0; bor_i = 1'b1; cyc(3); bor_i = 1'b0; cyc(2);
    chk("R5 disabled brown-out no reset", int'(sysrst_o), 0);
    chk("R5 disabled brown-out no flag", int'(cause_o), 8'h10);
    boren_i = 1'b1; bor_i = 1'b1; cyc(2); bor_i = 1'b0;
    chk("R5 brown-out flag", int'(cause_o), 8'h12);
    measure(n);
    chk_rng("R5 brown-out skips power-on delay", n, 28, 44);
    cyc(2);

    // R8: trap and illegal opcode, partial clear
    trap_i = 1'b1; cyc(1); trap_i = 1'b0;
    illop_i = 1'b1; cyc(1); illop_i = 1'b0;
    chk("R8 trap and illegal bits", int'(cause_o), 8'hD2);
    measure(n);
    clr_we_i = 1'b1; clr_mask_i = 8'h42; cyc(1); clr_we_i = 1'b0;
    chk("R10 partial clear", int'(cause_o), 8'h90);
    cyc(2);

    // R4/R9: time-out settings after power-on pulses
    pwrt_sel_i = 2'd0; pulse_por();
    chk("R9 por cause", int'(cause_o), 8'h01);
    measure(n);
    chk_rng("R4 select 00", n, 34, 50);
    cyc(2);
    pwrt_sel_i = 2'd2; pulse_por();
    measure(n);
    chk_rng("R4 select 10", n, 160, 180);
    cyc(2);
    pwrt_sel_i = 2'd3; pulse_por();
    measure(n);
    chk_rng("R4 select 11", n, 545, 565);
    cyc(4);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule